// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block turns a cache read miss into a four-beat burst on a 32-bit memory port and refills one 16-byte line. The burst begins at the word that missed. It then wraps around the line, so the processor gets its data after the first beat and does not wait for the whole line. That word goes back on a one-cycle response strobe. While the processor carries on, the other three words arrive in a line buffer. The full 128-bit line is then written to the cache data array in a single cycle.

The block accepts one miss at a time, and a new miss waits until the current line write has finished. Each beat waits for the memory ready input. A snoop invalidate that hits the line being filled cancels the line write: the block raises a kill strobe in place of the write enable. Tag lookup, replacement choice and DRAM timing are handled elsewhere.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset the block is idle: missReady is 1 and memReq, cpuValid, lineWrEn and fillKilled are 0.
- R2: An accepted miss produces exactly four accepted beats (memReq and memReady both high). Let c be missAddr[3:2]. Beat i addresses word (c+i) mod 4 of the same 16-byte line. memAddr[1:0] is always 0.
- R3: In the cycle after the first accepted beat, cpuValid is high for exactly one cycle and cpuData equals the data of that beat. There is exactly one such pulse per fill.
- R4: A cycle with memReq high and memReady low does not advance the burst: memReq stays high and memAddr is unchanged in the next cycle.
- R5: In the cycle after the fourth accepted beat, lineWrEn is high for one cycle and lineWrAddr holds the miss address with bits [3:0] cleared. lineWrData bits [32k+31:32k] hold the word read from byte offset 4k of the line.
- R6: missReady is low from the cycle after a miss is accepted until the cycle after the line write or kill. A miss held during that time is accepted afterwards and filled correctly.
- R7: If snoopValid is high while a fill is in progress and snoopAddr[ADDR_W-1:4] equals the line being filled, the end of the fill raises fillKilled for one cycle instead of lineWrEn. The critical word is still delivered.
- R8: A snoop to any other line has no effect on the fill, and the line write happens as in R5.
- R9: memReq is high only while beats are outstanding. It is low once the fourth beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Read-miss request |
| missAddr | input | ADDR_W | Byte address of the missed word |
| missReady | output | 1 | Miss accepted when high together with missValid |
| cpuValid | output | 1 | One-cycle strobe carrying the critical word |
| cpuData | output | WORD_W | Critical word |
| memReq | output | 1 | Beat request to memory |
| memAddr | output | ADDR_W | Word address of the current beat |
| memReady | input | 1 | Memory has data for the current beat |
| memData | input | WORD_W | Beat data |
| snoopValid | input | 1 | Snoop invalidate strobe |
| snoopAddr | input | ADDR_W | Snooped byte address |
| lineWrEn | output | 1 | Write the finished line into the data array |
| lineWrAddr | output | ADDR_W | Line-aligned address of the write |
| lineWrData | output | 4*WORD_W | Whole line, word 0 in the low bits |
| fillKilled | output | 1 | Fill ended without a write because of a snoop hit |

## Verification
The hardest case to reach from the ports is a second miss that arrives while a fill with a wrapped order is running. The check must show that this miss waits and that its own burst starts with its own critical word. The stimulus holds the second miss valid from the cycle after the first is accepted. It then watches missReady through the line write, clears the event log at that point and checks the second burst on its own. The snoop cases are timed in cycles from acceptance so that the invalidate falls in the middle of the burst. A separate run alternates memReady each cycle to exercise beats that are held without advancing.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int LINE_WORDS = 4;
  localparam int BEAT_W = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_WRITE = 2'd2
  } fillState_t;

  typedef struct packed {
    logic              loadMiss;
    logic              storeWord;
    logic              firstWord;
    logic [BEAT_W-1:0] beatIdx;
  } fillStrobe_t;
endpackage

// File: rtl/lfc_datapath.sv
module lfc_datapath
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fillStrobe_t                stb,
  input  logic [ADDR_W-1:0]          missAddr,
  input  logic [WORD_W-1:0]          memData,
  input  logic [ADDR_W-1:0]          snoopAddr,
  output logic                       snoopMatch,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       cpuValid,
  output logic [WORD_W-1:0]          cpuData,
  output logic [ADDR_W-1:0]          lineAddr,
  output logic [LINE_WORDS*WORD_W-1:0] lineData
);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int LINE_OFF = BYTE_OFF + BEAT_W;
  localparam int TAG_W = ADDR_W - LINE_OFF;

  logic [TAG_W-1:0]  lineBase;
  logic [BEAT_W-1:0] critIdx;
  logic [BEAT_W-1:0] slotIdx;
  logic              cpuValidQ;
  logic [WORD_W-1:0] cpuDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBase <= '0;
      critIdx  <= '0;
    end else if (stb.loadMiss) begin
      lineBase <= missAddr[ADDR_W-1:LINE_OFF];
      critIdx  <= missAddr[LINE_OFF-1:BYTE_OFF];
    end
  end

  // wrapping word order: critical word first, then modulo the line
  assign slotIdx = critIdx + stb.beatIdx;
  assign memAddr = {lineBase, slotIdx, {BYTE_OFF{1'b0}}};

  genvar w;
  generate
    for (w = 0; w < LINE_WORDS; w++) begin : g_slot
      logic [WORD_W-1:0] slotQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (stb.storeWord && slotIdx == BEAT_W'(w)) begin
          slotQ <= memData;
        end
      end
      assign lineData[w*WORD_W +: WORD_W] = slotQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuValidQ <= 1'b0;
      cpuDataQ  <= '0;
    end else begin
      cpuValidQ <= stb.storeWord && stb.firstWord;
      if (stb.storeWord && stb.firstWord) begin
        cpuDataQ <= memData;
      end
    end
  end

  assign cpuValid   = cpuValidQ;
  assign cpuData    = cpuDataQ;
  assign lineAddr   = {lineBase, {LINE_OFF{1'b0}}};
  assign snoopMatch = (snoopAddr[ADDR_W-1:LINE_OFF] == lineBase);
endmodule

// File: rtl/lfc_control.sv
module lfc_control
  import lfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memReady,
  input  logic        snoopValid,
  input  logic        snoopMatch,
  output fillStrobe_t stb,
  output logic        missReady,
  output logic        memReq,
  output logic        lineWrEn,
  output logic        fillKilled
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  fillState_t        state;
  fillState_t        stateNext;
  logic [BEAT_W-1:0] beatQ;
  logic              killedQ;
  logic              snoopHit;
  logic              killNow;

  assign snoopHit = snoopValid && snoopMatch && (state != ST_IDLE);
  assign killNow  = killedQ || snoopHit;

  always_comb begin
    stb.loadMiss  = (state == ST_IDLE) && missValid;
    stb.storeWord = (state == ST_BURST) && memReady;
    stb.firstWord = (beatQ == '0);
    stb.beatIdx   = beatQ;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (missValid) stateNext = ST_BURST;
      ST_BURST: if (memReady && beatQ == LAST_BEAT) stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatQ   <= '0;
      killedQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.loadMiss) begin
        beatQ   <= '0;
        killedQ <= 1'b0;
      end else begin
        if (stb.storeWord) beatQ <= beatQ + 1'b1;
        if (snoopHit) killedQ <= 1'b1;
      end
    end
  end

  assign missReady  = (state == ST_IDLE);
  assign memReq     = (state == ST_BURST);
  assign lineWrEn   = (state == ST_WRITE) && !killNow;
  assign fillKilled = (state == ST_WRITE) && killNow;
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         missValid,
  input  logic [ADDR_W-1:0]            missAddr,
  output logic                         missReady,
  output logic                         cpuValid,
  output logic [WORD_W-1:0]            cpuData,
  output logic                         memReq,
  output logic [ADDR_W-1:0]            memAddr,
  input  logic                         memReady,
  input  logic [WORD_W-1:0]            memData,
  input  logic                         snoopValid,
  input  logic [ADDR_W-1:0]            snoopAddr,
  output logic                         lineWrEn,
  output logic [ADDR_W-1:0]            lineWrAddr,
  output logic [LINE_WORDS*WORD_W-1:0] lineWrData,
  output logic                         fillKilled
);
  fillStrobe_t stb;
  logic        snoopMatch;

  lfc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .missValid  (missValid),
    .memReady   (memReady),
    .snoopValid (snoopValid),
    .snoopMatch (snoopMatch),
    .stb        (stb),
    .missReady  (missReady),
    .memReq     (memReq),
    .lineWrEn   (lineWrEn),
    .fillKilled (fillKilled)
  );

  lfc_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .missAddr   (missAddr),
    .memData    (memData),
    .snoopAddr  (snoopAddr),
    .snoopMatch (snoopMatch),
    .memAddr    (memAddr),
    .cpuValid   (cpuValid),
    .cpuData    (cpuData),
    .lineAddr   (lineWrAddr),
    .lineData   (lineWrData)
  );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missReady,
  input logic              memReq,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              cpuValid,
  input logic              lineWrEn,
  input logic              fillKilled
);
  // R3: the response strobe follows an accepted beat and lasts one cycle
  a_r3_cpu_after_beat: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> $past(memReq && memReady));
  a_r3_cpu_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> !cpuValid);
  // R4: a stalled beat keeps its request and address
  a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));
  // R5: the line write follows an accepted beat
  a_r5_write_after_beat: assert property (@(posedge clk) disable iff (!rstN)
    lineWrEn |-> $past(memReq && memReady));
  // R6: an accepted miss closes the request port
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> !missReady);
  // R7: write and kill never together
  a_r7_write_or_kill: assert property (@(posedge clk) disable iff (!rstN)
    !(lineWrEn && fillKilled));
  // R2: beat addresses are word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
  // R9: no request in the cycle of the line write
  a_r9_quiet_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (lineWrEn || fillKilled) |-> !memReq);
endmodule

bind line_fill_ctrl lfc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .missValid  (missValid),
  .missReady  (missReady),
  .memReq     (memReq),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .cpuValid   (cpuValid),
  .lineWrEn   (lineWrEn),
  .fillKilled (fillKilled)
);

// File: tb/sim_line_fill_ctrl.sv
`timescale 1ns/1ps
module sim_line_fill_ctrl;
  localparam int AW = 32;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          missValid = 1'b0;
  logic [AW-1:0] missAddr = '0;
  logic          missReady;
  logic          cpuValid;
  logic [WW-1:0] cpuData;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic          memReady = 1'b0;
  logic [WW-1:0] memData;
  logic          snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;
  logic          lineWrEn;
  logic [AW-1:0] lineWrAddr;
  logic [4*WW-1:0] lineWrData;
  logic          fillKilled;

  int checks = 0;
  int errors = 0;
  int readyMode = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  line_fill_ctrl #(.ADDR_W(AW), .WORD_W(WW)) u0 (.*);

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  assign memData = memWord(memAddr);

  always @(posedge clk) begin
    if (readyMode == 0) memReady <= 1'b1;
    else memReady <= ~memReady;
  end

  // event log, sampled between edges
  int cyc = 0;
  int beatCnt, cpuCnt, lineCnt, killCnt;
  int firstBeatCyc, lastBeatCyc, cpuCyc, lineCyc;
  logic [AW-1:0] beatAddr [0:7];
  logic [WW-1:0] cpuWord;
  logic [4*WW-1:0] lineData;
  logic [AW-1:0] lineA;

  task automatic clearLog();
    beatCnt = 0; cpuCnt = 0; lineCnt = 0; killCnt = 0;
    firstBeatCyc = 0; lastBeatCyc = 0; cpuCyc = 0; lineCyc = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN && memReq && memReady) begin
      if (beatCnt < 8) beatAddr[beatCnt] = memAddr;
      if (beatCnt == 0) firstBeatCyc = cyc;
      lastBeatCyc = cyc;
      beatCnt++;
    end
    if (rstN && cpuValid) begin cpuCnt++; cpuWord = cpuData; cpuCyc = cyc; end
    if (rstN && lineWrEn) begin lineCnt++; lineData = lineWrData; lineA = lineWrAddr; lineCyc = cyc; end
    if (rstN && fillKilled) killCnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 60 && (lineCnt + killCnt) == 0; i++) tick();
  endtask

  // verifies beats, critical word and (optionally) the line write of one fill
  task automatic checkFill(input logic [AW-1:0] a, input bit expectWrite);
    logic [AW-1:0] base;
    logic [4*WW-1:0] expLine;
    base = {a[AW-1:4], 4'h0};
    check(beatCnt == 4, "R2 beat count", beatCnt, 4);
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] ea;
      ea = base + {26'd0, 2'(a[3:2] + 2'(i)), 4'd0} / 4;
      ea = base + 32'((int'(a[3:2]) + i) % 4 * 4);
      check(beatAddr[i] == ea, "R2 beat address", beatAddr[i], ea);
    end
    check(cpuCnt == 1, "R3 response count", cpuCnt, 1);
    check(cpuWord == memWord({a[AW-1:2], 2'b00}), "R3 critical word", cpuWord, memWord({a[AW-1:2], 2'b00}));
    check(cpuCyc == firstBeatCyc + 1, "R3 response timing", cpuCyc, firstBeatCyc + 1);
    for (int k = 0; k < 4; k++) expLine[k*WW +: WW] = memWord(base + 32'(4*k));
    if (expectWrite) begin
      check(lineCnt == 1 && killCnt == 0, "R5 single line write", {lineCnt, killCnt}, {32'd1, 32'd0});
      check(lineCyc == lastBeatCyc + 1, "R5 write timing", lineCyc, lastBeatCyc + 1);
      check(lineA == base, "R5 write address", lineA, base);
      check(lineData == expLine, "R5 line data", lineData, expLine);
    end else begin
      check(lineCnt == 0 && killCnt == 1, "R7 kill instead of write", {lineCnt, killCnt}, {32'd0, 32'd1});
    end
    tick();
    check(!memReq, "R9 request released", memReq, 0);
    check(missReady, "R6 port reopened", missReady, 1);
  endtask

  // snoopKind: 0 none, 1 same line, 2 other line
  task automatic runFill(input logic [AW-1:0] a, input int mode, input int snoopKind);
    readyMode = mode;
    clearLog();
    missValid = 1'b1; missAddr = a;
    tick();
    missValid = 1'b0;
    if (snoopKind != 0) begin
      tick();
      snoopValid = 1'b1;
      snoopAddr = (snoopKind == 1) ? (a ^ 32'h0000_000C) : (a ^ 32'h0000_0040);
      tick();
      snoopValid = 1'b0;
    end
    waitEnd();
    checkFill(a, snoopKind != 1);
  endtask

  task automatic testReset();
    check(missReady == 1'b1, "R1 missReady idle", missReady, 1);
    check(!memReq && !cpuValid, "R1 no request or response", {memReq, cpuValid}, 0);
    check(!lineWrEn && !fillKilled, "R1 no write or kill", {lineWrEn, fillKilled}, 0);
  endtask

  task automatic testStall();
    logic [AW-1:0] a1, a2;
    bit sawOpen;
    a1 = 32'h0000_2A34; a2 = 32'h0000_7F08;
    readyMode = 0;
    clearLog();
    missValid = 1'b1; missAddr = a1;
    tick();
    missAddr = a2;   // second miss held valid
    sawOpen = 0;
    for (int i = 0; i < 60 && (lineCnt + killCnt) == 0; i++) begin
      if (missReady) sawOpen = 1;
      tick();
    end
    check(!sawOpen, "R6 port closed during fill", sawOpen, 0);
    check(lineA == {a1[AW-1:4], 4'h0} && lineCnt == 1, "R6 first line written", lineA, {a1[AW-1:4], 4'h0});
    check(beatAddr[0] == {a1[AW-1:2], 2'b00}, "R6 first burst order", beatAddr[0], {a1[AW-1:2], 2'b00});
    clearLog();
    for (int i = 0; i < 10 && !missReady; i++) tick();
    tick();
    missValid = 1'b0;
    waitEnd();
    checkFill(a2, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearLog();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();                        // R1
    runFill(32'h0000_1000, 0, 0);       // R2 R3 R5: critical word 0
    runFill(32'h0000_2468, 0, 0);       // R2: wrap from word 2
    runFill(32'h0001_0ABC, 1, 0);       // R4: ready gaps, wrap from word 3
    runFill(32'h0000_3004, 0, 1);       // R7: snoop hit kills the write
    runFill(32'h0000_4008, 0, 2);       // R8: snoop on other line ignored
    testStall();                        // R6: second miss waits
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule